// File: doc/BRIEF.md
# Level Interrupt Change Forwarder

This block mirrors a vector of level-sensitive interrupts between the two ends of a chip-to-chip link. On the sending side it registers the local interrupt inputs every cycle and compares each new sample with the one before. Any difference raises a request for a high-priority message whose payload is the interrupt vector. The request stays up until the message channel grants it. If further changes arrive while the request waits, they fold into that one message, and the message carries whatever vector is newest at the moment of the grant.

On the receiving side, an update from the far end overwrites a local output register, so the outputs always show the last vector that was transferred. The two directions are independent of each other. A source should hold each level for at least 16 cycles. Levels that toggle faster than the message channel can deliver may collapse into a single update.

The block also keeps three sticky error flags: far-end reset while the link is active, a multi-bit receive error, and a configuration mismatch between the two ends. Any set flag raises an error interrupt. Only reset clears the flags.

Top module: `irq_level_mirror`

## Requirements
- R1: After reset, `tx_req`, `irq_out`, `err_flags` and `err_irq` are all zero, and a zero input vector raises no request.
- R2: Suppose `irq_in` changes before clock edge k and `tx_req` is low. `tx_req` stays low after edge k and is high after edge k+1.
- R3: While `tx_req` is high and `tx_gnt` is low at a clock edge, `tx_req` stays high after that edge.
- R4: A message is transferred at each clock edge where `tx_req` and `tx_gnt` are both high. Its payload is `tx_vec`, which equals the `irq_in` value sampled at the most recent edge. Several changes made before a grant therefore produce one message carrying the last vector.
- R5: After a grant edge, `tx_req` is low. This holds even when a new input change is detected in the grant cycle, because that change is already part of the granted payload.
- R6: While `irq_in` stays constant and no request is pending, `tx_req` stays low.
- R7: When `rx_valid` is high at a clock edge, `irq_out` takes `rx_vec` after that edge. Otherwise `irq_out` holds its value and `rx_vec` has no effect.
- R8: `err_flags[0]` (link error) sets after an edge where `peer_reset_evt` and `link_active` are both high. A `peer_reset_evt` while `link_active` is low has no effect.
- R9: `err_flags[1]` sets after an edge where `multibit_evt` is high. `err_flags[2]` sets after an edge where `cfg_mismatch_evt` is high.
- R10: Once set, an error flag stays set until reset.
- R11: `err_irq` is high exactly when at least one bit of `err_flags` is set.
- R12: Receiving an update and waiting to send one can happen in the same cycles without either path disturbing the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | IRQ_W | Local level interrupts to forward |
| tx_gnt | input | 1 | Message channel accepts the pending update |
| tx_req | output | 1 | Request for a high-priority update message |
| tx_vec | output | IRQ_W | Payload of the update message |
| rx_valid | input | 1 | Update from the far end is present |
| rx_vec | input | IRQ_W | Interrupt vector carried by the received update |
| irq_out | output | IRQ_W | Mirrored interrupt levels from the far end |
| link_active | input | 1 | Link is in normal operation |
| peer_reset_evt | input | 1 | Far end was seen to reset |
| multibit_evt | input | 1 | Several bits were received in error |
| cfg_mismatch_evt | input | 1 | Configurations of the two ends disagree |
| err_flags | output | 3 | Sticky flags: bit 0 link, bit 1 multibit, bit 2 configuration |
| err_irq | output | 1 | OR of the sticky flags |

## Verification
The interesting coincidence is a freshly detected input change landing in the same cycle as the grant of the request already pending. The bench holds `tx_gnt` low until a request for one vector is waiting, then drives a second vector so that its detection lines up with a one-cycle grant. The scoreboard expects exactly one message, carrying the second vector. After that cycle `tx_req` must stay low, with no duplicate message. The second overlap is a received update arriving while a send request is stalled, which is judged by both `irq_out` and the later payload.

// File: rtl/irq_mirror_pkg.sv
package irq_mirror_pkg;
  // Sticky error flag positions, shared by RTL and bench
  localparam int ERR_LINK  = 0;
  localparam int ERR_MBIT  = 1;
  localparam int ERR_CFG   = 2;
  localparam int ERR_COUNT = 3;

  typedef logic [ERR_COUNT-1:0] err_vec_t;
endpackage

// File: rtl/irq_change_sender.sv
module irq_change_sender #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic             tx_gnt,
  output logic             tx_req,
  output logic [IRQ_W-1:0] tx_vec,
  output logic             chg_o
);
  logic [IRQ_W-1:0] samp_q;
  logic [IRQ_W-1:0] prev_q;
  logic             req_q;
  logic             grant_hit;

  // Nonzero difference between two samples
  function automatic logic level_delta(input logic [IRQ_W-1:0] a,
                                       input logic [IRQ_W-1:0] b);
    return |(a ^ b);
  endfunction

  assign chg_o     = level_delta(samp_q, prev_q);
  assign grant_hit = req_q & tx_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
      req_q  <= 1'b0;
    end else begin
      samp_q <= irq_in;
      prev_q <= samp_q;
      // a pending request absorbs later changes; grant carries newest sample
      if (req_q) req_q <= ~tx_gnt;
      else       req_q <= chg_o;
    end
  end

  assign tx_req = req_q;
  assign tx_vec = samp_q;

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_gnt) |=> tx_req);

  a_r5_drop_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hit |=> !tx_req);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_o && !tx_req) |=> tx_req);

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_o && !tx_req) |=> !tx_req);
endmodule

// File: rtl/irq_update_receiver.sv
module irq_update_receiver #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [IRQ_W-1:0] rx_vec,
  output logic [IRQ_W-1:0] irq_out
);
  logic [IRQ_W-1:0] mirror_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mirror_q <= '0;
    else if (rx_valid) mirror_q <= rx_vec;
  end

  assign irq_out = mirror_q;

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (irq_out == $past(rx_vec)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(irq_out));
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank
  import irq_mirror_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     link_active,
  input  logic     peer_reset_evt,
  input  logic     multibit_evt,
  input  logic     cfg_mismatch_evt,
  output err_vec_t err_flags,
  output logic     err_irq
);
  err_vec_t set_v;
  err_vec_t flag_q;

  always_comb begin
    set_v           = '0;
    set_v[ERR_LINK] = peer_reset_evt & link_active;
    set_v[ERR_MBIT] = multibit_evt;
    set_v[ERR_CFG]  = cfg_mismatch_evt;
  end

  for (genvar i = 0; i < ERR_COUNT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] |=> flag_q[i]);
  end

  assign err_flags = flag_q;
  assign err_irq   = |flag_q;

  a_r8_link_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !link_active |=> (err_flags[ERR_LINK] == $past(err_flags[ERR_LINK])));

  a_r9_mbit_set: assert property (@(posedge clk) disable iff (!rst_n)
    multibit_evt |=> err_flags[ERR_MBIT]);

  a_r11_irq_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_irq));
endmodule

// File: rtl/irq_level_mirror.sv
module irq_level_mirror
  import irq_mirror_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic             tx_gnt,
  output logic             tx_req,
  output logic [IRQ_W-1:0] tx_vec,
  input  logic             rx_valid,
  input  logic [IRQ_W-1:0] rx_vec,
  output logic [IRQ_W-1:0] irq_out,
  input  logic             link_active,
  input  logic             peer_reset_evt,
  input  logic             multibit_evt,
  input  logic             cfg_mismatch_evt,
  output logic [2:0]       err_flags,
  output logic             err_irq
);
  logic     chg_evt;
  err_vec_t flags_w;

  irq_change_sender #(.IRQ_W(IRQ_W)) u_send (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .tx_gnt (tx_gnt),
    .tx_req (tx_req),
    .tx_vec (tx_vec),
    .chg_o  (chg_evt)
  );

  irq_update_receiver #(.IRQ_W(IRQ_W)) u_recv (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_vec   (rx_vec),
    .irq_out  (irq_out)
  );

  err_sticky_bank u_err (
    .clk              (clk),
    .rst_n            (rst_n),
    .link_active      (link_active),
    .peer_reset_evt   (peer_reset_evt),
    .multibit_evt     (multibit_evt),
    .cfg_mismatch_evt (cfg_mismatch_evt),
    .err_flags        (flags_w),
    .err_irq          (err_irq)
  );

  assign err_flags = flags_w;

  // R12: a stalled send request must not block capture of received updates
  a_r12_paths_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tx_req && !tx_gnt) |=> (tx_req && irq_out == $past(rx_vec)));
endmodule

// File: tb/irq_level_mirror_tb_top.sv
module irq_level_mirror_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] irq_in = '0;
  logic         tx_gnt = 1'b0;
  logic         tx_req;
  logic [W-1:0] tx_vec;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_vec = '0;
  logic [W-1:0] irq_out;
  logic         link_active = 1'b0;
  logic         peer_reset_evt = 1'b0;
  logic         multibit_evt = 1'b0;
  logic         cfg_mismatch_evt = 1'b0;
  logic [2:0]   err_flags;
  logic         err_irq;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  irq_level_mirror #(.IRQ_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tx_gnt(tx_gnt),
    .tx_req(tx_req), .tx_vec(tx_vec), .rx_valid(rx_valid), .rx_vec(rx_vec),
    .irq_out(irq_out), .link_active(link_active),
    .peer_reset_evt(peer_reset_evt), .multibit_evt(multibit_evt),
    .cfg_mismatch_evt(cfg_mismatch_evt), .err_flags(err_flags),
    .err_irq(err_irq)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic at_post();
    @(posedge clk); #5;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic pulse_evt(input int which);
    at_post();
    case (which)
      0: peer_reset_evt = 1'b1;
      1: multibit_evt = 1'b1;
      default: cfg_mismatch_evt = 1'b1;
    endcase
    at_post();
    peer_reset_evt = 1'b0; multibit_evt = 1'b0; cfg_mismatch_evt = 1'b0;
    at_neg();
  endtask

  // Scoreboard monitor: a transfer happens at the next edge when req and gnt are high
  always @(negedge clk) begin
    if (rst_n && tx_req && tx_gnt) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected message", tx_vec, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(tx_vec == e, "R4 payload", tx_vec, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) at_post();
    rst_n = 1'b1;
    at_neg();
    // R1 reset state
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);
    chk(irq_out == '0, "R1 irq_out", irq_out, 0);
    chk(err_flags == 3'b000, "R1 err_flags", err_flags, 0);
    chk(err_irq == 1'b0, "R1 err_irq", err_irq, 0);

    // R6 stable inputs raise nothing
    tx_gnt = 1'b1;
    for (int i = 0; i < 6; i++) begin
      at_neg();
      chk(tx_req == 1'b0, "R6 quiet", tx_req, 0);
    end

    // R2 latency of request
    at_post();
    irq_in = 8'h05;
    exp_q.push_back(8'h05);
    at_neg();
    at_neg();
    chk(tx_req == 1'b0, "R2 not yet", tx_req, 0);
    at_neg();
    chk(tx_req == 1'b1, "R2 raised", tx_req, 1);
    at_neg();
    chk(tx_req == 1'b0, "R5 dropped after grant", tx_req, 0);

    // R4 several patterns with immediate grant
    foreach (exp_q[i]) ;
    begin
      logic [W-1:0] pats [4] = '{8'hFF, 8'h80, 8'h00, 8'h3C};
      for (int i = 0; i < 4; i++) begin
        at_post();
        irq_in = pats[i];
        exp_q.push_back(pats[i]);
        repeat (5) at_neg();
      end
    end
    chk(exp_q.size() == 0, "R4 all forwarded", exp_q.size(), 0);

    // R12 and R7: receive while a send is stalled
    tx_gnt = 1'b0;
    at_post();
    irq_in = 8'h5A;
    exp_q.push_back(8'h5A);
    rx_valid = 1'b1;
    rx_vec = 8'hA5;
    at_post();
    rx_valid = 1'b0;
    rx_vec = 8'hFF;
    at_neg();
    chk(irq_out == 8'hA5, "R7 capture", irq_out, 8'hA5);
    at_neg();
    chk(irq_out == 8'hA5, "R7 hold ignores rx_vec", irq_out, 8'hA5);
    chk(tx_req == 1'b1, "R12 send still pending", tx_req, 1);
    at_post();
    tx_gnt = 1'b1;
    repeat (3) at_neg();
    chk(exp_q.size() == 0, "R12 stalled message delivered", exp_q.size(), 0);
    chk(irq_out == 8'hA5, "R12 mirror intact", irq_out, 8'hA5);

    // R4 coalescing and R3 hold
    at_post();
    tx_gnt = 1'b0;
    irq_in = 8'h11;
    repeat (3) at_post();
    irq_in = 8'h22;
    repeat (3) at_post();
    irq_in = 8'h33;
    exp_q.push_back(8'h33);
    repeat (3) at_neg();
    chk(tx_req == 1'b1, "R3 held without grant", tx_req, 1);
    at_post();
    tx_gnt = 1'b1;
    at_post();
    tx_gnt = 1'b0;
    repeat (4) at_neg();
    chk(tx_req == 1'b0, "R4 single coalesced message", tx_req, 0);
    chk(exp_q.size() == 0, "R4 coalesced delivered", exp_q.size(), 0);

    // R5 change detected in the grant cycle
    at_post();
    irq_in = 8'h44;
    repeat (4) at_post();
    irq_in = 8'h99;
    exp_q.push_back(8'h99);
    at_post();
    tx_gnt = 1'b1;
    at_post();
    tx_gnt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      at_neg();
      chk(tx_req == 1'b0, "R5 no duplicate request", tx_req, 0);
    end
    chk(exp_q.size() == 0, "R5 newest vector sent", exp_q.size(), 0);

    // R8 gated link error
    link_active = 1'b0;
    pulse_evt(0);
    chk(err_flags == 3'b000, "R8 ignored when link idle", err_flags, 0);
    chk(err_irq == 1'b0, "R11 low with no flags", err_irq, 0);
    link_active = 1'b1;
    pulse_evt(0);
    chk(err_flags == 3'b001, "R8 link error", err_flags, 3'b001);
    chk(err_irq == 1'b1, "R11 raised", err_irq, 1);
    pulse_evt(1);
    chk(err_flags == 3'b011, "R9 multibit", err_flags, 3'b011);
    pulse_evt(2);
    chk(err_flags == 3'b111, "R9 config", err_flags, 3'b111);
    repeat (20) at_neg();
    chk(err_flags == 3'b111, "R10 sticky", err_flags, 3'b111);
    chk(err_irq == 1'b1, "R11 still high", err_irq, 1);

    // R10 reset clears
    at_post();
    irq_in = '0;
    rst_n = 1'b0;
    at_post();
    rst_n = 1'b1;
    at_neg();
    chk(err_flags == 3'b000, "R10 cleared by reset", err_flags, 0);
    chk(irq_out == '0, "R1 mirror reset", irq_out, 0);
    chk(err_irq == 1'b0, "R11 low after reset", err_irq, 0);
    repeat (3) at_neg();
    chk(tx_req == 1'b0, "R1 no request after reset", tx_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule